// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block holds the per-ID interrupt state of a small interrupt controller and exposes it on a 32-bit register bus. The ID space is split into three kinds. IDs 0 to 15 are raised only by software. IDs 16 to 31 are private hardware lines that are fixed to level mode. IDs 32 and up are shared hardware lines whose mode is chosen per ID. Software sets and clears enables and pending bits by writing ones into paired word registers. It programs an urgency and a CPU destination for each ID through byte-wide fields. Writing a single generation register raises a software interrupt.

On every cycle the block drives the pending, enabled, priority and destination state of every ID toward one CPU interface, together with the global forwarding enable. The CPU interface reports a taken interrupt on the acknowledge input, which drops the latched pending state of that ID. The block samples the hardware lines itself. In edge mode it captures a rising transition. In level mode it follows the registered line.

Top module: `irqd_distributor`

## Requirements
- R1: After reset every pending, enable, priority, destination, shared mode bit and control bit is zero, so `irq_pend`, `irq_en` and `dist_en` are all zero.
- R2: The control word at byte offset 0x000 stores bits 1:0, and bit 0 drives `dist_en`. Writing 3 reads back 3.
- R3: The word at 0x004 is read-only. It returns NUM_IDS/32-1 in bits 4:0 and NUM_CPUS-1 in bits 7:5 (0x00000001 by default), and writes to it have no effect.
- R4: Enable words: a 1 written to bit id%32 of the word at 0x100+4*(id/32) enables that ID, and a 1 written to the same position at 0x180 disables it. Zero bits have no effect. Both offsets read the enable state, and `irq_en` changes on the write edge.
- R5: Pending words at 0x200 (set) and 0x280 (clear) use the same bit layout. The set word latches pending in either mode. The clear word drops the latch, but a level ID whose line is high stays pending.
- R6: The priority byte of an ID is at 0x400+id, and only the lanes with `bus_be` set are written. Bits 7:4 are stored and bits 3:0 read as zero. `irq_prio[4*id+:4]` carries the stored nibble, and a lower value means more urgent.
- R7: The destination byte of an ID is at 0x800+id, written per byte lane. Its low NUM_CPUS bits are stored and drive `irq_tgt`, and the other bits read as zero.
- R8: Mode words at 0xC00+4*(id/16) hold bit 2*(id%16)+1 = 1 for edge and 0 for level, and bit 2*(id%16) reads zero. IDs 0-15 always read edge and IDs 16-31 always read level, whatever is written.
- R9: In edge mode, a line that is low at one clock edge and high at the next sets pending on that second edge. Pending then stays set after the line falls, until an acknowledge or a clear-pending write. A line held high does not set it again.
- R10: In level mode, pending equals the line as registered on the previous edge. It drops one edge after the line falls, unless it is latched.
- R11: A write to 0xF00 with bit 16 set marks the ID in bits 3:0 (0-15) pending. With bit 16 clear the write has no effect.
- R12: `ack_valid` with `ack_id` clears the latched pending state of that ID on the same edge. A set event on the same edge takes priority.
- R13: A read presented with `bus_rd` returns `bus_rdata` with `bus_rvalid` high in the following cycle. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Word address (byte address bits 11:2) |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte lane enables for priority and destination writes |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| irq_hw | input | NUM_IDS-16 | Hardware lines for IDs 16 and up (bit 0 is ID 16) |
| ack_valid | input | 1 | Acknowledge from the CPU interface |
| ack_id | input | clog2(NUM_IDS) | Acknowledged ID |
| dist_en | output | 1 | Global forwarding enable |
| irq_pend | output | NUM_IDS | Pending state per ID |
| irq_en | output | NUM_IDS | Enable state per ID |
| irq_prio | output | 4*NUM_IDS | Priority nibble per ID |
| irq_tgt | output | NUM_CPUS*NUM_IDS | Destination bits per ID |

## Verification
Register writes, acknowledges and edge captures act on the clock edge that samples them, so their effect on the outputs is due one edge after the input is driven. A level line appears one edge after it is driven and disappears one edge after it is removed. Read data arrives in the cycle after the read strobe. The bench drives every input on the falling edge and samples the per-ID outputs on the next falling edge. A monitor compares read data against a queue of expected words on each falling edge where `bus_rvalid` is high, so a value that comes one cycle late or early lands on the wrong entry and is reported.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

   // word addresses (byte offset >> 2)
   localparam logic [9:0] W_CTRL  = 10'h000;
   localparam logic [9:0] W_TYPE  = 10'h001;
   localparam logic [9:0] W_ENSET = 10'h040;
   localparam logic [9:0] W_ENCLR = 10'h060;
   localparam logic [9:0] W_PDSET = 10'h080;
   localparam logic [9:0] W_PDCLR = 10'h0A0;
   localparam logic [9:0] W_PRIO  = 10'h100;
   localparam logic [9:0] W_TGT   = 10'h200;
   localparam logic [9:0] W_CFG   = 10'h300;
   localparam logic [9:0] W_SGI   = 10'h3C0;

   localparam int SOFT_IDS  = 16;
   localparam int FIXED_IDS = 32;
   localparam int PRIO_W    = 4;

   typedef enum logic [1:0] {
      KIND_SOFT   = 2'd0,
      KIND_PRIV   = 2'd1,
      KIND_SHARED = 2'd2
   } id_kind_e;

   function automatic id_kind_e kind_of(input int id);
      if (id < SOFT_IDS) return KIND_SOFT;
      if (id < FIXED_IDS) return KIND_PRIV;
      return KIND_SHARED;
   endfunction

endpackage

// File: rtl/irqd_wr_decode.sv
module irqd_wr_decode
   import irqd_pkg::*;
#(
   parameter int NUM_IDS = 64
) (
   input  logic                     bus_wr,
   input  logic [9:0]               bus_addr,
   input  logic [31:0]              bus_wdata,
   input  logic [3:0]               bus_be,
   output logic                     ctrl_we,
   output logic [NUM_IDS-1:0]       en_set,
   output logic [NUM_IDS-1:0]       en_clr,
   output logic [NUM_IDS-1:0]       pd_set,
   output logic [NUM_IDS-1:0]       pd_clr,
   output logic [NUM_IDS-1:0]       prio_we,
   output logic [NUM_IDS-1:0]       tgt_we,
   output logic [NUM_IDS-33:0]      cfg_we,
   output logic [SOFT_IDS-1:0]      sgi_set
);

   localparam int NSHARED = NUM_IDS - FIXED_IDS;

   logic sgi_go;

   assign ctrl_we = bus_wr && (bus_addr == W_CTRL);
   assign sgi_go  = bus_wr && (bus_addr == W_SGI) && bus_wdata[16];

   for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
      localparam logic [9:0] OW = 10'(i / 32);
      localparam logic [9:0] OB = 10'(i / 4);
      localparam int         BT = i % 32;
      localparam int         LN = i % 4;
      assign en_set[i]  = bus_wr && (bus_addr == W_ENSET + OW) && bus_wdata[BT];
      assign en_clr[i]  = bus_wr && (bus_addr == W_ENCLR + OW) && bus_wdata[BT];
      assign pd_set[i]  = bus_wr && (bus_addr == W_PDSET + OW) && bus_wdata[BT];
      assign pd_clr[i]  = bus_wr && (bus_addr == W_PDCLR + OW) && bus_wdata[BT];
      assign prio_we[i] = bus_wr && (bus_addr == W_PRIO + OB) && bus_be[LN];
      assign tgt_we[i]  = bus_wr && (bus_addr == W_TGT + OB) && bus_be[LN];
   end

   for (genvar j = 0; j < NSHARED; j++) begin : g_cfg
      localparam logic [9:0] OC = 10'((j + FIXED_IDS) / 16);
      assign cfg_we[j] = bus_wr && (bus_addr == W_CFG + OC);
   end

   for (genvar k = 0; k < SOFT_IDS; k++) begin : g_sgi
      assign sgi_set[k] = sgi_go && (bus_wdata[3:0] == 4'(k));
   end

endmodule

// File: rtl/irqd_src_slot.sv
module irqd_src_slot
   import irqd_pkg::*;
#(
   parameter int NUM_CPUS = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_in,
   input  logic                edge_mode,
   input  logic                en_set,
   input  logic                en_clr,
   input  logic                pd_set,
   input  logic                pd_clr,
   input  logic                sgi_set,
   input  logic                ack_hit,
   input  logic                prio_we,
   input  logic [PRIO_W-1:0]   prio_wd,
   input  logic                tgt_we,
   input  logic [NUM_CPUS-1:0] tgt_wd,
   output logic                pend,
   output logic                en,
   output logic [PRIO_W-1:0]   prio,
   output logic [NUM_CPUS-1:0] tgt
);

   logic line_q;
   logic latch_q;
   logic rise;

   assign rise = edge_mode & line_in & ~line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= 1'b0;
         latch_q <= 1'b0;
         en      <= 1'b0;
         prio    <= '0;
         tgt     <= '0;
      end else begin
         line_q <= line_in;
         if (pd_set || sgi_set || rise)
            latch_q <= 1'b1;
         else if (pd_clr || ack_hit)
            latch_q <= 1'b0;
         if (en_set)
            en <= 1'b1;
         else if (en_clr)
            en <= 1'b0;
         if (prio_we)
            prio <= prio_wd;
         if (tgt_we)
            tgt <= tgt_wd;
      end
   end

   assign pend = latch_q | (~edge_mode & line_q);

endmodule

// File: rtl/irqd_rd_mux.sv
module irqd_rd_mux
   import irqd_pkg::*;
#(
   parameter int NUM_IDS  = 64,
   parameter int NUM_CPUS = 1
) (
   input  logic [9:0]                   bus_addr,
   input  logic [1:0]                   ctrl,
   input  logic [NUM_IDS-1:0]           en,
   input  logic [NUM_IDS-1:0]           pend,
   input  logic [NUM_IDS-1:0]           edge_vec,
   input  logic [NUM_IDS*PRIO_W-1:0]    prio_flat,
   input  logic [NUM_IDS*NUM_CPUS-1:0]  tgt_flat,
   output logic [31:0]                  rdata
);

   localparam int NW = NUM_IDS / 32;
   localparam int NB = NUM_IDS / 4;
   localparam int NC = NUM_IDS / 16;

   always_comb begin
      rdata = '0;
      if (bus_addr == W_CTRL)
         rdata = {30'b0, ctrl};
      if (bus_addr == W_TYPE)
         rdata = {24'b0, 3'(NUM_CPUS - 1), 5'(NW - 1)};
      for (int w = 0; w < NW; w++) begin
         if (bus_addr == W_ENSET + 10'(w) || bus_addr == W_ENCLR + 10'(w))
            rdata = en[w*32 +: 32];
         if (bus_addr == W_PDSET + 10'(w) || bus_addr == W_PDCLR + 10'(w))
            rdata = pend[w*32 +: 32];
      end
      for (int b = 0; b < NB; b++) begin
         if (bus_addr == W_PRIO + 10'(b))
            for (int l = 0; l < 4; l++)
               rdata[8*l+4 +: PRIO_W] = prio_flat[(4*b+l)*PRIO_W +: PRIO_W];
         if (bus_addr == W_TGT + 10'(b))
            for (int l = 0; l < 4; l++)
               rdata[8*l +: NUM_CPUS] = tgt_flat[(4*b+l)*NUM_CPUS +: NUM_CPUS];
      end
      for (int c = 0; c < NC; c++) begin
         if (bus_addr == W_CFG + 10'(c))
            for (int j = 0; j < 16; j++)
               rdata[2*j+1] = edge_vec[16*c+j];
      end
   end

endmodule

// File: rtl/irqd_distributor.sv
module irqd_distributor
   import irqd_pkg::*;
#(
   parameter  int NUM_IDS  = 64,
   parameter  int NUM_CPUS = 1,
   localparam int IDW      = $clog2(NUM_IDS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_wr,
   input  logic                         bus_rd,
   input  logic [11:2]                  bus_addr,
   input  logic [31:0]                  bus_wdata,
   input  logic [3:0]                   bus_be,
   output logic [31:0]                  bus_rdata,
   output logic                         bus_rvalid,
   input  logic [NUM_IDS-17:0]          irq_hw,
   input  logic                         ack_valid,
   input  logic [IDW-1:0]               ack_id,
   output logic                         dist_en,
   output logic [NUM_IDS-1:0]           irq_pend,
   output logic [NUM_IDS-1:0]           irq_en,
   output logic [NUM_IDS*PRIO_W-1:0]    irq_prio,
   output logic [NUM_IDS*NUM_CPUS-1:0]  irq_tgt
);

   if (NUM_IDS % 32 != 0 || NUM_IDS < 64 || NUM_IDS > 1024) begin : g_bad_ids
      $error("NUM_IDS must be a multiple of 32 between 64 and 1024");
   end
   if (NUM_CPUS < 1 || NUM_CPUS > 8) begin : g_bad_cpus
      $error("NUM_CPUS must lie between 1 and 8");
   end

   logic                      ctrl_we;
   logic [1:0]                ctrl_q;
   logic [NUM_IDS-1:0]        en_set, en_clr, pd_set, pd_clr;
   logic [NUM_IDS-1:0]        prio_we, tgt_we;
   logic [NUM_IDS-33:0]       cfg_we;
   logic [SOFT_IDS-1:0]       sgi_set;
   logic [NUM_IDS-1:0]        ack_hit;
   logic [NUM_IDS-1:0]        edge_vec;
   logic [NUM_IDS-1:0]        line_w;
   logic [NUM_IDS-1:0]        sgi_w;
   logic [31:0]               rdata_c;

   irqd_wr_decode #(.NUM_IDS(NUM_IDS)) u_dec (
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_be    (bus_be),
      .ctrl_we   (ctrl_we),
      .en_set    (en_set),
      .en_clr    (en_clr),
      .pd_set    (pd_set),
      .pd_clr    (pd_clr),
      .prio_we   (prio_we),
      .tgt_we    (tgt_we),
      .cfg_we    (cfg_we),
      .sgi_set   (sgi_set)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= 2'b00;
      else if (ctrl_we)
         ctrl_q <= bus_wdata[1:0];
   end
   assign dist_en = ctrl_q[0];

   for (genvar i = 0; i < NUM_IDS; i++) begin : g_src
      localparam id_kind_e KIND = kind_of(i);
      localparam int       LN   = i % 4;

      assign ack_hit[i] = ack_valid && (ack_id == IDW'(i));

      if (KIND == KIND_SOFT) begin : g_soft
         assign edge_vec[i] = 1'b1;
         assign line_w[i]   = 1'b0;
         assign sgi_w[i]    = sgi_set[i];
      end else if (KIND == KIND_PRIV) begin : g_priv
         assign edge_vec[i] = 1'b0;
         assign line_w[i]   = irq_hw[i-SOFT_IDS];
         assign sgi_w[i]    = 1'b0;
      end else begin : g_shared
         logic cfg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cfg_q <= 1'b0;
            else if (cfg_we[i-FIXED_IDS])
               cfg_q <= bus_wdata[2*(i%16)+1];
         end
         assign edge_vec[i] = cfg_q;
         assign line_w[i]   = irq_hw[i-SOFT_IDS];
         assign sgi_w[i]    = 1'b0;
      end

      irqd_src_slot #(.NUM_CPUS(NUM_CPUS)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .line_in   (line_w[i]),
         .edge_mode (edge_vec[i]),
         .en_set    (en_set[i]),
         .en_clr    (en_clr[i]),
         .pd_set    (pd_set[i]),
         .pd_clr    (pd_clr[i]),
         .sgi_set   (sgi_w[i]),
         .ack_hit   (ack_hit[i]),
         .prio_we   (prio_we[i]),
         .prio_wd   (bus_wdata[8*LN+4 +: PRIO_W]),
         .tgt_we    (tgt_we[i]),
         .tgt_wd    (bus_wdata[8*LN +: NUM_CPUS]),
         .pend      (irq_pend[i]),
         .en        (irq_en[i]),
         .prio      (irq_prio[i*PRIO_W +: PRIO_W]),
         .tgt       (irq_tgt[i*NUM_CPUS +: NUM_CPUS])
      );
   end

   irqd_rd_mux #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS)) u_rd (
      .bus_addr  (bus_addr),
      .ctrl      (ctrl_q),
      .en        (irq_en),
      .pend      (irq_pend),
      .edge_vec  (edge_vec),
      .prio_flat (irq_prio),
      .tgt_flat  (irq_tgt),
      .rdata     (rdata_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_rd;
         if (bus_rd)
            bus_rdata <= rdata_c;
      end
   end

endmodule

// File: rtl/irqd_checker.sv
module irqd_checker
   import irqd_pkg::*;
#(
   parameter int NUM_IDS = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic [9:0]         bus_addr,
   input logic [3:0]         wd_id,
   input logic               wd_b0,
   input logic               wd_b16,
   input logic               bus_rvalid,
   input logic               dist_en,
   input logic [31:0]        pend_lo,
   input logic [15:0]        priv_lines,
   input logic [NUM_IDS-1:0] irq_en,
   input logic [NUM_IDS-1:0] en_set,
   input logic [NUM_IDS-1:0] en_clr,
   input logic [15:0]        pd_clr_soft,
   input logic [15:0]        ack_soft
);

   // R2
   ctrl_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == W_CTRL) |=> (dist_en == $past(wd_b0)));

   // R13
   rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_rvalid);

   // R13
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> !bus_rvalid);

   for (genvar i = 0; i < NUM_IDS; i++) begin : g_en
      // R4
      en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         en_set[i] |=> irq_en[i]);
      // R4
      en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en_clr[i] && !en_set[i]) |=> !irq_en[i]);
   end

   for (genvar k = 0; k < SOFT_IDS; k++) begin : g_soft
      // R9
      sgi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_lo[k] && !pd_clr_soft[k] && !ack_soft[k]) |=> pend_lo[k]);
      // R11
      sgi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == W_SGI && wd_b16 && wd_id == 4'(k)) |=> pend_lo[k]);
      // R10
      lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         priv_lines[k] |=> pend_lo[k+16]);
   end

endmodule

bind irqd_distributor irqd_checker #(.NUM_IDS(NUM_IDS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .bus_addr    (bus_addr),
   .wd_id       (bus_wdata[3:0]),
   .wd_b0       (bus_wdata[0]),
   .wd_b16      (bus_wdata[16]),
   .bus_rvalid  (bus_rvalid),
   .dist_en     (dist_en),
   .pend_lo     (irq_pend[31:0]),
   .priv_lines  (irq_hw[15:0]),
   .irq_en      (irq_en),
   .en_set      (en_set),
   .en_clr      (en_clr),
   .pd_clr_soft (pd_clr[15:0]),
   .ack_soft    (ack_hit[15:0])
);

// File: tb/irqd_distributor_test.sv
`timescale 1ns/1ps
module irqd_distributor_test;

   localparam int NUM_IDS  = 64;
   localparam int NUM_CPUS = 1;
   localparam int IDW      = $clog2(NUM_IDS);

   logic                        clk = 1'b0;
   logic                        rst_n = 1'b0;
   logic                        bus_wr = 1'b0;
   logic                        bus_rd = 1'b0;
   logic [11:0]                 bus_byte = '0;
   logic [31:0]                 bus_wdata = '0;
   logic [3:0]                  bus_be = 4'hF;
   logic [31:0]                 bus_rdata;
   logic                        bus_rvalid;
   logic [NUM_IDS-17:0]         irq_hw = '0;
   logic                        ack_valid = 1'b0;
   logic [IDW-1:0]              ack_id = '0;
   logic                        dist_en;
   logic [NUM_IDS-1:0]          irq_pend;
   logic [NUM_IDS-1:0]          irq_en;
   logic [NUM_IDS*4-1:0]        irq_prio;
   logic [NUM_IDS*NUM_CPUS-1:0] irq_tgt;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] exp_w;
   string       tag_w;

   always #5 clk = ~clk;

   irqd_distributor #(.NUM_IDS(NUM_IDS), .NUM_CPUS(NUM_CPUS)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_addr   (bus_byte[11:2]),
      .bus_wdata  (bus_wdata),
      .bus_be     (bus_be),
      .bus_rdata  (bus_rdata),
      .bus_rvalid (bus_rvalid),
      .irq_hw     (irq_hw),
      .ack_valid  (ack_valid),
      .ack_id     (ack_id),
      .dist_en    (dist_en),
      .irq_pend   (irq_pend),
      .irq_en     (irq_en),
      .irq_prio   (irq_prio),
      .irq_tgt    (irq_tgt)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
      @(negedge clk);
      bus_wr = 1'b1; bus_byte = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = 4'hF;
   endtask

   // driver: queue the expected word, the monitor compares it
   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_byte = a;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ack(input int id);
      @(negedge clk);
      ack_valid = 1'b1; ack_id = IDW'(id);
      @(negedge clk);
      ack_valid = 1'b0;
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // monitor
   always @(negedge clk) begin
      if (bus_rvalid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R13: unexpected read data %h, expected none", bus_rdata);
         end else begin
            exp_w = exp_q.pop_front();
            tag_w = tag_q.pop_front();
            check(bus_rdata == exp_w, tag_w, 64'(bus_rdata), 64'(exp_w));
         end
      end
   end

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      check(irq_pend == '0, "R1 pending after reset", 64'(irq_pend), 64'd0);
      check(irq_en == '0, "R1 enable after reset", 64'(irq_en), 64'd0);
      check(dist_en == 1'b0, "R1 dist_en after reset", 64'(dist_en), 64'd0);
      rd(12'h000, 32'h0, "R1 control reads zero");
      rd(12'h400, 32'h0, "R1 priority reads zero");

      // R3 type word
      rd(12'h004, 32'h1, "R3 type word");
      wr(12'h004, 32'hFFFF_FFFF);
      rd(12'h004, 32'h1, "R3 type word after write");

      // R2 control
      wr(12'h000, 32'h3);
      check(dist_en == 1'b1, "R2 dist_en set", 64'(dist_en), 64'd1);
      rd(12'h000, 32'h3, "R2 control readback");
      wr(12'h000, 32'h0);
      check(dist_en == 1'b0, "R2 dist_en cleared", 64'(dist_en), 64'd0);

      // R4 enables
      wr(12'h104, 32'h5);
      check(irq_en == (64'h5 << 32), "R4 enable set", 64'(irq_en), 64'h5 << 32);
      wr(12'h104, 32'h0);
      check(irq_en == (64'h5 << 32), "R4 zero write no effect", 64'(irq_en), 64'h5 << 32);
      wr(12'h184, 32'h1);
      check(irq_en == (64'h4 << 32), "R4 enable clear", 64'(irq_en), 64'h4 << 32);
      rd(12'h104, 32'h4, "R4 set word readback");
      rd(12'h184, 32'h4, "R4 clear word readback");
      rd(12'h100, 32'h0, "R4 word0 readback");

      // R6 priority byte lanes
      wr(12'h428, 32'hA53C_FF12, 4'b0101);
      rd(12'h428, 32'h0030_0010, "R6 priority lanes and low nibble");
      check(irq_prio[40*4 +: 4] == 4'h1, "R6 prio id40", 64'(irq_prio[40*4 +: 4]), 64'h1);
      check(irq_prio[42*4 +: 4] == 4'h3, "R6 prio id42", 64'(irq_prio[42*4 +: 4]), 64'h3);
      check(irq_prio[41*4 +: 4] == 4'h0, "R6 prio id41 untouched", 64'(irq_prio[41*4 +: 4]), 64'h0);

      // R7 destinations
      wr(12'h800, 32'hFFFF_FFFF);
      rd(12'h800, 32'h0101_0101, "R7 destination readback");
      check(irq_tgt[3:0] == 4'hF, "R7 destination outputs", 64'(irq_tgt[3:0]), 64'hF);

      // R8 mode words
      wr(12'hC00, 32'h0);
      rd(12'hC00, 32'hAAAA_AAAA, "R8 soft IDs fixed edge");
      wr(12'hC04, 32'hFFFF_FFFF);
      rd(12'hC04, 32'h0, "R8 private IDs fixed level");
      wr(12'hC08, 32'h3);
      rd(12'hC08, 32'h2, "R8 shared mode bit");

      // R9 edge capture on id32 (line 16)
      @(negedge clk); irq_hw[16] = 1'b1;
      @(negedge clk);
      check(irq_pend[32] == 1'b1, "R9 edge sets pending", 64'(irq_pend[32]), 64'd1);
      irq_hw[16] = 1'b0;
      tick(3);
      check(irq_pend[32] == 1'b1, "R9 pending held after line falls", 64'(irq_pend[32]), 64'd1);
      ack(32);
      check(irq_pend[32] == 1'b0, "R12 ack clears edge pending", 64'(irq_pend[32]), 64'd0);
      @(negedge clk); irq_hw[16] = 1'b1;
      @(negedge clk);
      check(irq_pend[32] == 1'b1, "R9 second edge", 64'(irq_pend[32]), 64'd1);
      ack(32);
      tick(2);
      check(irq_pend[32] == 1'b0, "R9 held line does not retrigger", 64'(irq_pend[32]), 64'd0);
      irq_hw[16] = 1'b0;

      // R10 level on id33 (line 17)
      @(negedge clk); irq_hw[17] = 1'b1;
      @(negedge clk);
      check(irq_pend[33] == 1'b1, "R10 level follows line", 64'(irq_pend[33]), 64'd1);
      irq_hw[17] = 1'b0;
      @(negedge clk);
      check(irq_pend[33] == 1'b0, "R10 level drops", 64'(irq_pend[33]), 64'd0);

      // R5 pending words
      wr(12'h204, 32'h8);
      check(irq_pend[35] == 1'b1, "R5 set pending level id", 64'(irq_pend[35]), 64'd1);
      rd(12'h204, 32'h8, "R5 pending readback");
      wr(12'h284, 32'h8);
      check(irq_pend[35] == 1'b0, "R5 clear pending", 64'(irq_pend[35]), 64'd0);
      @(negedge clk); irq_hw[20] = 1'b1;
      @(negedge clk);
      wr(12'h284, 32'h10);
      check(irq_pend[36] == 1'b1, "R5 clear leaves high level line", 64'(irq_pend[36]), 64'd1);
      irq_hw[20] = 1'b0;
      @(negedge clk);
      check(irq_pend[36] == 1'b0, "R5 level gone after line low", 64'(irq_pend[36]), 64'd0);
      wr(12'h204, 32'h8);
      ack(35);
      check(irq_pend[35] == 1'b0, "R12 ack clears latched level", 64'(irq_pend[35]), 64'd0);

      // R11 software generation
      wr(12'hF00, 32'h0001_0005);
      check(irq_pend[5] == 1'b1, "R11 generate id5", 64'(irq_pend[5]), 64'd1);
      wr(12'hF00, 32'h0000_0006);
      check(irq_pend[6] == 1'b0, "R11 no destination no effect", 64'(irq_pend[6]), 64'd0);
      rd(12'h200, 32'h20, "R11 pending word0");
      ack(5);
      check(irq_pend[5] == 1'b0, "R12 ack clears soft id", 64'(irq_pend[5]), 64'd0);

      // R13 unmapped
      rd(12'hE00, 32'h0, "R13 unmapped reads zero");
      tick(3);
      check(exp_q.size() == 0, "R13 all reads answered", 64'(exp_q.size()), 64'd0);
      finish_run();
   end

endmodule